// File: doc/BRIEF.md
# Parallel Flash Page Programmer with Verify and Resume

This block programs one page of a byte-wide parallel flash device from a local source buffer and then confirms the result. After a start pulse it sends the three-write program-unlock command, then copies the page byte by byte from the source buffer to the flash. Bytes that already read as erased (0xFF) are not written. Once the copy is finished it polls the toggle status bit at the last page address until the device is idle. It then reads the page back and compares it with the buffer.

When the read-back does not match, the block starts again from the first failing byte instead of from byte zero. It sends the unlock command again and programs only the rest of the page. The number of such retries is fixed. At the end of each run the block gives a one-cycle done pulse with a fail flag and the index of the page. The caller must erase the page before starting.

Top module: `pp_page_prog`

## Requirements
- R1: Each programming pass begins with three consecutive write cycles: data 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555.
- R2: In a pass, page bytes are handled in increasing index order. A byte equal to 0xFF produces no write cycle. Any other byte at index i is written to address page_base + i.
- R3: After the data writes of a pass, the flash is read only at the last page address until bit 6 has the same value in two consecutive reads. No other address is read while the device is busy.
- R4: Verification reads every page address from index 0 upward and compares each with the source byte. It stops at the first mismatch.
- R5: On a mismatch with retries left, the block issues R1's unlock again and programs from the failing index to the end of the page. Verification then restarts at index 0.
- R6: At most 16 retries are made. If the 17th verification still mismatches, the run ends with fail_o high.
- R7: done_o is a one-cycle pulse. fail_o and fail_page_o (page_base_i shifted right by log2 of the page size) are valid with it. They hold until the next accepted start, and that start clears fail_o.
- R8: A start pulse or a change of page_base_i during a run has no effect on that run.
- R9: Out of reset, done_o, fail_o, fl_we_o, fl_re_o and src_rd_o are low.
- R10: The low log2(page size) bits of page_base_i are ignored, so the page is always aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a page run (accepted when idle) |
| page_base_i | input | ADDR_W | Flash address of the page |
| src_rd_o | output | 1 | Source buffer read enable |
| src_addr_o | output | log2(PAGE_BYTES) | Source buffer byte index |
| src_data_i | input | 8 | Source byte, valid one cycle after src_rd_o |
| fl_we_o | output | 1 | Flash write strobe, one cycle per write |
| fl_re_o | output | 1 | Flash read strobe |
| fl_addr_o | output | ADDR_W | Flash address |
| fl_wdata_o | output | 8 | Flash write data |
| fl_rdata_i | input | 8 | Flash read data, valid one cycle after fl_re_o |
| done_o | output | 1 | End-of-run pulse |
| fail_o | output | 1 | Run ended with a mismatch after all retries |
| fail_page_o | output | ADDR_W-log2(PAGE_BYTES) | Index of the page of the last run |

## Verification
A wrong retry index or a lost count of retries shows up at once as a misplaced or missing write in the next pass. A skipped 0xFF check shows up as an extra write cycle. A wrong end-of-poll condition shows up as a verify read while the device model still reports busy, one or two cycles after the last data write. A wrong retry limit shows up only at done, as a different total number of passes and a wrong fail_o value.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_UNLK, S_PREQ, S_PWR, S_POLL, S_VREQ, S_VCMP, S_FIN
  } pp_state_e;

  localparam logic [15:0] CMD_ADDR_A = 16'h5555;
  localparam logic [15:0] CMD_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  CMD_KEY0   = 8'hAA;
  localparam logic [7:0]  CMD_KEY1   = 8'h55;
  localparam logic [7:0]  CMD_PROG   = 8'hA0;
  localparam logic [7:0]  BLANK_BYTE = 8'hFF;
  localparam int          TOGGLE_BIT = 6;
endpackage

// File: rtl/pp_toggle_poll.sv
module pp_toggle_poll (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tog_i,
  output logic rd_o,
  output logic ready_o
);
  logic phase_q, have_q, prev_q;

  // phase 0: issue read, phase 1: read data valid
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      have_q  <= 1'b0;
      prev_q  <= 1'b0;
    end else if (!en_i) begin
      phase_q <= 1'b0;
      have_q  <= 1'b0;
    end else if (!phase_q) begin
      phase_q <= 1'b1;
    end else begin
      phase_q <= 1'b0;
      have_q  <= 1'b1;
      prev_q  <= tog_i;
    end
  end

  assign rd_o    = en_i && !phase_q;
  assign ready_o = en_i && phase_q && have_q && (tog_i == prev_q);
endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
  import pp_pkg::*;
#(
  parameter int PAGE_BYTES = 64,
  parameter int ADDR_W     = 17,
  parameter int MAX_RETRY  = 16,
  localparam int IDX_W     = $clog2(PAGE_BYTES),
  localparam int PG_W      = ADDR_W - IDX_W,
  localparam int TRY_W     = $clog2(MAX_RETRY + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] page_base_i,
  output logic              src_rd_o,
  output logic [IDX_W-1:0]  src_addr_o,
  input  logic [7:0]        src_data_i,
  input  logic [7:0]        fl_rdata_i,
  output logic              poll_en_o,
  input  logic              poll_rd_i,
  input  logic              poll_ready_i,
  output logic              fl_we_o,
  output logic              fl_re_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_wdata_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [PG_W-1:0]   fail_page_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_BYTES - 1);
  localparam logic [TRY_W-1:0] TRY_LIM  = TRY_W'(MAX_RETRY);

  pp_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic [1:0]       step_q;
  logic [TRY_W-1:0] tries_q;
  logic [PG_W-1:0]  page_q;
  logic             fail_q;
  logic             mismatch;

  logic unused_base_lsb;
  assign unused_base_lsb = ^page_base_i[IDX_W-1:0];

  assign mismatch = (src_data_i != fl_rdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      step_q  <= '0;
      tries_q <= '0;
      page_q  <= '0;
      fail_q  <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          page_q  <= page_base_i[ADDR_W-1:IDX_W];
          idx_q   <= '0;
          tries_q <= '0;
          fail_q  <= 1'b0;
          step_q  <= '0;
          state_q <= S_UNLK;
        end
        S_UNLK: begin
          if (step_q == 2'd2) begin
            step_q  <= '0;
            state_q <= S_PREQ;
          end else begin
            step_q <= step_q + 2'd1;
          end
        end
        S_PREQ: state_q <= S_PWR;
        S_PWR: begin
          if (idx_q == LAST_IDX) begin
            idx_q   <= '0;
            state_q <= S_POLL;
          end else begin
            idx_q   <= idx_q + IDX_W'(1);
            state_q <= S_PREQ;
          end
        end
        S_POLL: if (poll_ready_i) state_q <= S_VREQ;
        S_VREQ: state_q <= S_VCMP;
        S_VCMP: begin
          if (mismatch) begin
            if (tries_q == TRY_LIM) begin
              fail_q  <= 1'b1;
              state_q <= S_FIN;
            end else begin
              // keep idx_q: resume from the failing byte
              tries_q <= tries_q + TRY_W'(1);
              state_q <= S_UNLK;
            end
          end else if (idx_q == LAST_IDX) begin
            state_q <= S_FIN;
          end else begin
            idx_q   <= idx_q + IDX_W'(1);
            state_q <= S_VREQ;
          end
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    src_rd_o   = 1'b0;
    fl_we_o    = 1'b0;
    fl_re_o    = 1'b0;
    fl_addr_o  = {page_q, idx_q};
    fl_wdata_o = 8'h00;
    done_o     = 1'b0;
    unique case (state_q)
      S_UNLK: begin
        fl_we_o = 1'b1;
        unique case (step_q)
          2'd0:    begin fl_addr_o = ADDR_W'(CMD_ADDR_A); fl_wdata_o = CMD_KEY0; end
          2'd1:    begin fl_addr_o = ADDR_W'(CMD_ADDR_B); fl_wdata_o = CMD_KEY1; end
          default: begin fl_addr_o = ADDR_W'(CMD_ADDR_A); fl_wdata_o = CMD_PROG; end
        endcase
      end
      S_PREQ: src_rd_o = 1'b1;
      S_PWR: begin
        fl_we_o    = (src_data_i != BLANK_BYTE);
        fl_wdata_o = src_data_i;
      end
      S_POLL: begin
        fl_re_o   = poll_rd_i;
        fl_addr_o = {page_q, LAST_IDX};
      end
      S_VREQ: begin
        src_rd_o = 1'b1;
        fl_re_o  = 1'b1;
      end
      S_FIN:   done_o = 1'b1;
      default: ;
    endcase
  end

  assign src_addr_o  = idx_q;
  assign poll_en_o   = (state_q == S_POLL);
  assign fail_o      = fail_q;
  assign fail_page_o = page_q;
endmodule

// File: rtl/pp_page_prog.sv
module pp_page_prog
  import pp_pkg::*;
#(
  parameter int PAGE_BYTES = 64,
  parameter int ADDR_W     = 17,
  parameter int MAX_RETRY  = 16,
  localparam int IDX_W     = $clog2(PAGE_BYTES),
  localparam int PG_W      = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] page_base_i,
  output logic              src_rd_o,
  output logic [IDX_W-1:0]  src_addr_o,
  input  logic [7:0]        src_data_i,
  output logic              fl_we_o,
  output logic              fl_re_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_wdata_o,
  input  logic [7:0]        fl_rdata_i,
  output logic              done_o,
  output logic              fail_o,
  output logic [PG_W-1:0]   fail_page_o
);
  logic poll_en, poll_rd, poll_ready;

  pp_ctrl #(
    .PAGE_BYTES(PAGE_BYTES),
    .ADDR_W    (ADDR_W),
    .MAX_RETRY (MAX_RETRY)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .page_base_i (page_base_i),
    .src_rd_o    (src_rd_o),
    .src_addr_o  (src_addr_o),
    .src_data_i  (src_data_i),
    .fl_rdata_i  (fl_rdata_i),
    .poll_en_o   (poll_en),
    .poll_rd_i   (poll_rd),
    .poll_ready_i(poll_ready),
    .fl_we_o     (fl_we_o),
    .fl_re_o     (fl_re_o),
    .fl_addr_o   (fl_addr_o),
    .fl_wdata_o  (fl_wdata_o),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .fail_page_o (fail_page_o)
  );

  pp_toggle_poll u_poll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (poll_en),
    .tog_i  (fl_rdata_i[TOGGLE_BIT]),
    .rd_o   (poll_rd),
    .ready_o(poll_ready)
  );
endmodule

// File: rtl/pp_page_prog_chk.sv
module pp_page_prog_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              src_rd_o,
  input logic              fl_we_o,
  input logic              fl_re_o,
  input logic [ADDR_W-1:0] fl_addr_o,
  input logic [7:0]        fl_wdata_o,
  input logic              done_o,
  input logic              fail_o
);
  // R2: never drive read and write strobes together
  assert_bus_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fl_we_o && fl_re_o));

  // R2: a data write follows a buffer read and never carries 0xFF
  assert_skip_blank_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_we_o && $past(src_rd_o)) |-> (fl_wdata_o != 8'hFF));

  // R1: third of three back-to-back writes is the program key
  assert_unlock_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_we_o && $past(fl_we_o) && $past(fl_we_o, 2)) |->
      (fl_addr_o == ADDR_W'(17'h05555) && fl_wdata_o == 8'hA0));

  // R7: done lasts one cycle
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6: fail rises only with done
  assert_fail_at_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> done_o);

  // R7: fail clears only after a start request
  assert_fail_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fail_o) |-> $past(start_i));
endmodule

bind pp_page_prog pp_page_prog_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .src_rd_o  (src_rd_o),
  .fl_we_o   (fl_we_o),
  .fl_re_o   (fl_re_o),
  .fl_addr_o (fl_addr_o),
  .fl_wdata_o(fl_wdata_o),
  .done_o    (done_o),
  .fail_o    (fail_o)
);

// File: tb/sim_pp_page_prog.sv
module sim_pp_page_prog;
  localparam int PG = 64;
  localparam int AW = 17;
  localparam int IW = 6;
  localparam int BUSY_CYC = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          start;
  logic [AW-1:0] page_base;
  logic          src_rd;
  logic [IW-1:0] src_addr;
  logic [7:0]    src_q;
  logic          fl_we, fl_re;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_wdata, fl_rd;
  logic          done, fail;
  logic [AW-IW-1:0] fail_page;

  pp_page_prog u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .page_base_i(page_base),
    .src_rd_o(src_rd), .src_addr_o(src_addr), .src_data_i(src_q),
    .fl_we_o(fl_we), .fl_re_o(fl_re), .fl_addr_o(fl_addr),
    .fl_wdata_o(fl_wdata), .fl_rdata_i(fl_rd),
    .done_o(done), .fail_o(fail), .fail_page_o(fail_page)
  );

  typedef struct {
    int    kind;   // 0 write, 1 verify read, 2 done
    int    addr;   // page index for done
    int    data;   // fail flag for done
    string req;
  } exp_t;
  exp_t exp_q[$];

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0] src_buf [PG];
  logic [7:0] fl_mem  [PG];
  int         fl_drop [PG];
  int         fl_base;
  int         busy = 0;
  logic       tog = 1'b0;
  int         early_cnt = 0;
  int         mk;

  logic [7:0] t_src  [PG];
  logic [7:0] t_init [PG];
  int         t_drop [PG];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // source buffer: one cycle read latency
  always @(posedge clk) if (src_rd) src_q <= src_buf[src_addr];

  // flash model: bits only clear, programming busy window with toggling bit 6
  always @(posedge clk) begin
    if (busy > 0) busy <= busy - 1;
    if (fl_we && (int'(fl_addr) >> IW) == (fl_base >> IW)) begin
      mk = int'(fl_addr[IW-1:0]);
      if (fl_drop[mk] > 0) fl_drop[mk] <= fl_drop[mk] - 1;
      else fl_mem[mk] <= fl_mem[mk] & fl_wdata;
      busy <= BUSY_CYC;
    end
    if (fl_re) begin
      if (busy > 0) begin
        tog   <= ~tog;
        fl_rd <= {1'b0, tog, 6'b0};
        if (int'(fl_addr) != fl_base + PG - 1) early_cnt <= early_cnt + 1;
      end else begin
        fl_rd <= fl_mem[fl_addr[IW-1:0]];
      end
    end
  end

  // monitor
  bit poll_phase = 1'b0;
  bit first_rd   = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (fl_we) begin
        poll_phase = 1'b1;
        first_rd   = 1'b1;
        if (exp_q.size() == 0) check(0, "R2", "unexpected write addr", int'(fl_addr), -1);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check(e.kind == 0, e.req, "kind at write", 0, e.kind);
          check(int'(fl_addr) == e.addr, e.req, "write addr", int'(fl_addr), e.addr);
          check(int'(fl_wdata) == e.data, e.req, "write data", int'(fl_wdata), e.data);
        end
      end
      if (fl_re) begin
        if (first_rd) begin
          check(int'(fl_addr) == fl_base + PG - 1, "R3", "first read after writes",
                int'(fl_addr), fl_base + PG - 1);
          first_rd = 1'b0;
        end
        if (!(poll_phase && int'(fl_addr) == fl_base + PG - 1)) begin
          poll_phase = 1'b0;
          if (exp_q.size() == 0) check(0, "R4", "unexpected read addr", int'(fl_addr), -1);
          else begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.kind == 1, e.req, "kind at read", 1, e.kind);
            check(int'(fl_addr) == e.addr, e.req, "verify addr", int'(fl_addr), e.addr);
          end
        end
      end
      if (done) begin
        if (exp_q.size() == 0) check(0, "R6", "unexpected done", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check(e.kind == 2, e.req, "kind at done", 2, e.kind);
          check(int'(fail) == e.data, e.req, "fail flag", int'(fail), e.data);
          check(int'(fail_page) == e.addr, "R7", "fail page", int'(fail_page), e.addr);
        end
      end
    end
  end

  task automatic push(input int k, input int a, input int d, input string r);
    exp_t e;
    e.kind = k; e.addr = a; e.data = d; e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic run_page(input int base, input bit glitch);
    logic [7:0] m [PG];
    int d [PG];
    int s, tries, bad, pb, early0, exp_fail;
    pb = base & ~(PG - 1);   // R10: aligned page
    for (int i = 0; i < PG; i++) begin
      m[i] = t_init[i];
      d[i] = t_drop[i];
      src_buf[i] = t_src[i];
    end
    s = 0; tries = 0; exp_fail = 0;
    for (int pass = 0; pass < 40; pass++) begin
      push(0, 'h5555, 'hAA, "R1");
      push(0, 'h2AAA, 'h55, "R1");
      push(0, 'h5555, 'hA0, "R1");
      for (int i = s; i < PG; i++) begin
        if (t_src[i] != 8'hFF) begin
          push(0, pb + i, int'(t_src[i]), (pass == 0) ? "R2" : "R5");
          if (d[i] > 0) d[i]--;
          else m[i] = m[i] & t_src[i];
        end
      end
      bad = -1;
      for (int i = 0; i < PG; i++) begin
        push(1, pb + i, 0, "R4");
        if (m[i] != t_src[i]) begin bad = i; break; end
      end
      if (bad < 0) begin push(2, pb >> IW, 0, "R6"); break; end
      if (tries == 16) begin push(2, pb >> IW, 1, "R6"); exp_fail = 1; break; end
      tries++;
      s = bad;
    end
    @(negedge clk);
    for (int i = 0; i < PG; i++) begin
      fl_mem[i]  <= t_init[i];
      fl_drop[i] <= t_drop[i];
    end
    fl_base <= pb;
    early0 = early_cnt;
    @(negedge clk);
    start = 1'b1;
    page_base = AW'(base);
    @(negedge clk);
    start = 1'b0;
    check(fail == 1'b0, "R7", "fail cleared by start", int'(fail), 0);
    if (glitch) begin
      repeat (40) @(negedge clk);
      start = 1'b1;              // R8: must be ignored
      page_base = AW'('h1000);
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check(done == 1'b0, "R7", "done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    check(int'(fail) == exp_fail, "R7", "fail held", int'(fail), exp_fail);
    check(int'(fail_page) == (pb >> IW), "R7", "page held", int'(fail_page), pb >> IW);
    check(exp_q.size() == 0, "R5", "expected items left", exp_q.size(), 0);
    check(early_cnt == early0, "R3", "reads while busy", early_cnt - early0, 0);
    exp_q.delete();
  endtask

  task automatic base_pattern();
    for (int i = 0; i < PG; i++) begin
      t_src[i]  = 8'((i * 37 + 5) & 'hFF);
      t_init[i] = 8'hFF;
      t_drop[i] = 0;
    end
    t_src[3]  = 8'hFF;
    t_src[63] = 8'hFF;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    start = 1'b0;
    page_base = '0;
    fl_base = 0;
    for (int i = 0; i < PG; i++) begin
      fl_mem[i] = 8'hFF;
      fl_drop[i] = 0;
      src_buf[i] = 8'hFF;
    end
    repeat (3) @(negedge clk);
    // R9: reset state
    check(done == 1'b0, "R9", "done in reset", int'(done), 0);
    check(fail == 1'b0, "R9", "fail in reset", int'(fail), 0);
    check(fl_we == 1'b0 && fl_re == 1'b0, "R9", "strobes in reset", int'({fl_we, fl_re}), 0);
    check(src_rd == 1'b0, "R9", "src read in reset", int'(src_rd), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: mixed data with blank bytes, clean program
    base_pattern();
    run_page('h0400, 1'b0);

    // R2: all-blank source, top page of the address space
    for (int i = 0; i < PG; i++) t_src[i] = 8'hFF;
    run_page('h1FFC0, 1'b0);

    // R5: dropped programs force resume from failing index
    base_pattern();
    t_src[63] = 8'h12;
    t_drop[5] = 2; t_drop[40] = 1; t_drop[63] = 1;
    run_page('h0A80, 1'b0);

    // R6 and R10: unfixable byte, unaligned base
    base_pattern();
    t_src[10] = 8'hFF; t_init[10] = 8'h00;
    run_page('h0325, 1'b0);

    // R8: start and base change during a run are ignored
    base_pattern();
    run_page('h0800, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule